// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised universal shift register, eight bits wide by default. On each rising clock edge it holds its contents, shifts them one place toward the high end, shifts them one place toward the low end, or loads a parallel word. Two select inputs choose among these four operations. Each shift direction has its own serial input. The two end bits are always driven out as serial taps, so several instances can be chained into a longer word.

The parallel side models one shared bidirectional bus as three signals: the register contents (`io_out`), a drive-enable (`io_oe`) and the bus value seen by the block (`io_in`). The drivers turn off when either of two active-high high-impedance requests is set. They also turn off in load mode, when the outside world drives the bus and the register samples it. The register keeps shifting, holding, loading and resetting while its drivers are off.

An active-low reset clears the register at once, without waiting for a clock. Its release is synchronised to the clock, so the register first acts on the third rising edge after `rst_n` goes high.

Top module: `ushreg`

## Requirements
- R1: While `rst_n` is low, `io_out`, `tap_lo` and `tap_hi` are all zero, from the moment `rst_n` falls and whatever the clock or selects are doing.
- R2: After `rst_n` rises, the register stays zero through the first two rising edges and carries out the selected operation from the third rising edge on.
- R3: With `{sel1,sel0}` = 2'b00 (hold), the register keeps its value across the edge.
- R4: With `{sel1,sel0}` = 2'b01 (shift up), bit n moves to bit n+1, `ser_up_in` enters bit 0, and the old top bit (bit 7) is dropped.
- R5: With `{sel1,sel0}` = 2'b10 (shift down), bit n moves to bit n-1, `ser_dn_in` enters the top bit (bit 7), and the old bit 0 is dropped.
- R6: With `{sel1,sel0}` = 2'b11 (load), the register takes the value on `io_in` at the edge.
- R7: `io_oe` is 0 whenever `hiz_a` or `hiz_b` is 1, or `{sel1,sel0}` = 2'b11. In every other case it is 1.
- R8: Shift and load work the same with `hiz_a` or `hiz_b` set as with both clear.
- R9: `tap_lo` always equals bit 0 and `tap_hi` always equals bit 7 of `io_out`, including while `io_oe` is 0.
- R10: Outside load mode, `io_in` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; clears at once, release is synchronised |
| sel0 | input | 1 | Mode select, low bit |
| sel1 | input | 1 | Mode select, high bit |
| hiz_a | input | 1 | Active-high high-impedance request A |
| hiz_b | input | 1 | Active-high high-impedance request B |
| ser_up_in | input | 1 | Serial input entering bit 0 on shift up |
| ser_dn_in | input | 1 | Serial input entering the top bit on shift down |
| io_in | input | W (8) | Bus value seen by the block, sampled in load mode |
| io_out | output | W (8) | Register contents, driven onto the bus when io_oe is 1 |
| io_oe | output | 1 | Bus drive enable |
| tap_lo | output | 1 | Always-driven copy of bit 0 |
| tap_hi | output | 1 | Always-driven copy of the top bit |

## Verification
The bench loads distinct words, 3C, 81, 80 and 01, and then shifts them both ways. It feeds a constant 1 or 0 through the active serial input and drives the opposite value on the unused one. This separates a correct shift from a wrong direction, a wrong serial input and a lost end bit. The 80 and 01 words show that the end bit is dropped rather than wrapped around. Changing `io_in` during hold and shift cycles, while the outside drives the bus, shows that only load mode samples the port. Repeating shifts and loads under each high-impedance request shows that the register works independently of the drive-enable. A reset asserted between clock edges, followed by a load held through the release, pins down both the immediate clear and the exact edge on which operation resumes.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } ushreg_mode_e;
endpackage

// File: rtl/ushreg_rst_sync.sv
module ushreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[LAST];
endmodule

// File: rtl/ushreg_next.sv
module ushreg_next
  import ushreg_pkg::*;
#(
  parameter int W = 8
) (
  input  ushreg_mode_e mode,
  input  logic [W-1:0] cur,
  input  logic         ser_up,
  input  logic         ser_dn,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  localparam int TOP = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up_src;
    logic dn_src;
    if (i == 0) begin : g_low
      assign up_src = ser_up;
    end else begin : g_low_mid
      assign up_src = cur[i-1];
    end
    if (i == TOP) begin : g_high
      assign dn_src = ser_dn;
    end else begin : g_high_mid
      assign dn_src = cur[i+1];
    end

    always_comb begin
      unique case (mode)
        MODE_UP:   nxt[i] = up_src;
        MODE_DN:   nxt[i] = dn_src;
        MODE_LOAD: nxt[i] = din[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/ushreg_port_ctl.sv
module ushreg_port_ctl
  import ushreg_pkg::*;
(
  input  ushreg_mode_e mode,
  input  logic         hiz_a,
  input  logic         hiz_b,
  output logic         drive_en
);
  logic bus_in_use;

  always_comb begin
    bus_in_use = (mode == MODE_LOAD);
    drive_en   = !(hiz_a || hiz_b || bus_in_use);
  end
endmodule

// File: rtl/ushreg.sv
module ushreg
  import ushreg_pkg::*;
#(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel0,
  input  logic         sel1,
  input  logic         hiz_a,
  input  logic         hiz_b,
  input  logic         ser_up_in,
  input  logic         ser_dn_in,
  input  logic [W-1:0] io_in,
  output logic [W-1:0] io_out,
  output logic         io_oe,
  output logic         tap_lo,
  output logic         tap_hi
);
  localparam int TOP = W - 1;

  ushreg_mode_e mode;
  logic         rst_int_n;
  logic         upd_en;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  assign mode = ushreg_mode_e'({sel1, sel0});

  ushreg_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  ushreg_next #(.W(W)) u_next (
    .mode   (mode),
    .cur    (data_q),
    .ser_up (ser_up_in),
    .ser_dn (ser_dn_in),
    .din    (io_in),
    .nxt    (data_d)
  );

  ushreg_port_ctl u_port_ctl (
    .mode     (mode),
    .hiz_a    (hiz_a),
    .hiz_b    (hiz_b),
    .drive_en (io_oe)
  );

  assign upd_en = (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  data_q <= '0;
    else if (upd_en) data_q <= data_d;
  end

  assign io_out = data_q;
  assign tap_lo = data_q[0];
  assign tap_hi = data_q[TOP];
endmodule

// File: rtl/ushreg_chk.sv
module ushreg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_int_n,
  input logic         sel0,
  input logic         sel1,
  input logic         hiz_a,
  input logic         hiz_b,
  input logic         ser_up_in,
  input logic         ser_dn_in,
  input logic [W-1:0] io_in,
  input logic [W-1:0] io_out,
  input logic         io_oe,
  input logic         tap_lo,
  input logic         tap_hi
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (io_out == '0));

  // R3
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && !sel1 && !sel0) |=> $stable(io_out));

  // R4
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && !sel1 && sel0) |=> (io_out == {$past(io_out[W-2:0]), $past(ser_up_in)}));

  // R5
  shift_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && sel1 && !sel0) |=> (io_out == {$past(ser_dn_in), $past(io_out[W-1:1])}));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && sel1 && sel0) |=> (io_out == $past(io_in)));

  // R7
  oe_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_a || hiz_b) |-> !io_oe);

  // R7
  oe_off_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 && sel1) |-> !io_oe);

  // R9
  taps_chk: assert property (@(posedge clk)
    (tap_lo == io_out[0]) && (tap_hi == io_out[W-1]));
endmodule

bind ushreg ushreg_chk #(.W(W)) u_ushreg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .sel0      (sel0),
  .sel1      (sel1),
  .hiz_a     (hiz_a),
  .hiz_b     (hiz_b),
  .ser_up_in (ser_up_in),
  .ser_dn_in (ser_dn_in),
  .io_in     (io_in),
  .io_out    (io_out),
  .io_oe     (io_oe),
  .tap_lo    (tap_lo),
  .tap_hi    (tap_hi)
);

// File: tb/test_ushreg.sv
`timescale 1ns/1ps
module test_ushreg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sel0, sel1, hiz_a, hiz_b, ser_up_in, ser_dn_in;
  logic [W-1:0] io_in;
  logic [W-1:0] io_out;
  logic         io_oe, tap_lo, tap_hi;
  logic         ext_drv;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] model;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  ushreg i_ushreg (
    .clk(clk), .rst_n(rst_n), .sel0(sel0), .sel1(sel1),
    .hiz_a(hiz_a), .hiz_b(hiz_b), .ser_up_in(ser_up_in), .ser_dn_in(ser_dn_in),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compares register output after each edge with the scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(io_out === e, t, io_out, e);
      check({tap_hi, tap_lo} === {e[W-1], e[0]}, "R9 taps",
            {{(W-2){1'b0}}, tap_hi, tap_lo}, {{(W-2){1'b0}}, e[W-1], e[0]});
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic apply(input logic [1:0] m, input logic su, input logic sd,
                       input logic [W-1:0] din, input logic ext, input logic ha,
                       input logic hb, input string tag);
    logic exp_oe;
    @(negedge clk);
    {sel1, sel0} = m;
    ser_up_in = su; ser_dn_in = sd; io_in = din; ext_drv = ext;
    hiz_a = ha; hiz_b = hb;
    case (m)
      2'b01:   model = {model[W-2:0], su};
      2'b10:   model = {sd, model[W-1:1]};
      2'b11:   model = din;
      default: model = model;
    endcase
    exp_q.push_back(model);
    tag_q.push_back(tag);
    #1;
    exp_oe = !(ha || hb || (m == 2'b11));
    check(io_oe === exp_oe, "R7 io_oe", {7'd0, io_oe}, {7'd0, exp_oe});
    check(!(ext_drv && io_oe), "R7 bus contention", {7'd0, io_oe}, 8'h00);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; {sel1, sel0} = 2'b11; hiz_a = 0; hiz_b = 0;
    ser_up_in = 1; ser_dn_in = 1; io_in = 8'hA5; ext_drv = 1'b1;
    repeat (3) @(negedge clk);
    check(io_out === 8'h00, "R1 reset state", io_out, 8'h00);
    check({tap_hi, tap_lo} === 2'b00, "R1 taps in reset", {6'd0, tap_hi, tap_lo}, 8'h00);
    // R2: release between edges, load held; first two edges must not load
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(io_out === 8'h00, "R2 edge 1 after release", io_out, 8'h00);
    @(posedge clk); #1;
    check(io_out === 8'h00, "R2 edge 2 after release", io_out, 8'h00);
    @(posedge clk); #1;
    check(io_out === 8'hA5, "R2 edge 3 after release", io_out, 8'hA5);
    model = 8'hA5;

    apply(2'b11, 0, 1, 8'h3C, 1, 0, 0, "R6 load 3C");
    apply(2'b00, 1, 1, 8'hFF, 1, 1, 0, "R3/R10 hold, bus FF");
    apply(2'b00, 0, 0, 8'h00, 1, 0, 1, "R3/R10 hold, bus 00");
    apply(2'b01, 1, 0, 8'h55, 0, 0, 0, "R4 shift up in 1");
    apply(2'b01, 1, 0, 8'hAA, 0, 0, 0, "R4 shift up in 1");
    apply(2'b01, 0, 1, 8'h0F, 0, 0, 0, "R4 shift up in 0");
    apply(2'b10, 1, 0, 8'hF0, 0, 0, 0, "R5 shift down in 0");
    apply(2'b10, 0, 1, 8'h33, 0, 0, 0, "R5 shift down in 1");
    apply(2'b10, 0, 1, 8'hCC, 0, 0, 0, "R5 shift down in 1");
    apply(2'b01, 1, 0, 8'h99, 1, 1, 0, "R8/R10 shift up under hiz_a");
    apply(2'b10, 1, 0, 8'h66, 1, 0, 1, "R8/R10 shift down under hiz_b");
    apply(2'b11, 0, 0, 8'h81, 1, 0, 1, "R8 load 81 under hiz_b");
    apply(2'b11, 0, 0, 8'h80, 1, 1, 1, "R6 load 80");
    apply(2'b01, 0, 1, 8'hFF, 0, 0, 0, "R4 top bit dropped");
    apply(2'b11, 0, 0, 8'h01, 1, 0, 0, "R6 load 01");
    apply(2'b10, 1, 0, 8'hFF, 0, 0, 0, "R5 bit 0 dropped");
    for (int k = 0; k < W; k++)
      apply(2'b01, k[0], ~k[0], 8'h5A, 0, 0, 0, "R4 walk pattern");
    for (int k = 0; k < W; k++)
      apply(2'b10, ~k[1], k[1], 8'hA5, 0, k[0], 0, "R5 walk pattern");
    apply(2'b00, 0, 0, 8'h77, 1, 1, 1, "R3 hold under both hiz");
    drain();

    // R1: reset asserted between edges clears at once
    #2 rst_n = 1'b0;
    #1 check(io_out === 8'h00, "R1 immediate clear", io_out, 8'h00);
    @(negedge clk);
    {sel1, sel0} = 2'b00; ext_drv = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model = 8'h00;
    apply(2'b11, 0, 0, 8'hC3, 1, 0, 0, "R6 load after second reset");
    apply(2'b00, 0, 0, 8'h00, 0, 0, 0, "R3 hold");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule